// File: doc/BRIEF.md
# SD Host Status and Interrupt Unit

This block collects the events of an SD host controller and turns them into one level interrupt. The command engine and the data path deliver single-cycle event pulses; the card-detect and write-protect pins arrive asynchronously and are synchronized here. Events latch into sticky status bits. Software clears those bits by writing ones to them. Two mask bytes choose which sticky bits may raise the interrupt, and a global enable bit held in the block-length configuration word gates the result.

Card insertion and removal are derived from one detect input. The configuration word selects that input from two pins and sets its active polarity. Each change of the qualified detect level sets a sticky "detect changed" flag, and each absent-to-present transition also sets a sticky "inserted" flag. A small register port writes the configuration and clears the status. All registers are visible at the same time on parallel output ports.

Top module: `sdh_irq_unit`

## Requirements
- R1: After synchronous reset every status, mask and configuration output reads zero and `irq` is low.
- R2: A pulse on `evt_cmd[i]` sets `sts1[i]` at the next clock edge. The bit order is: 0 I/O-card interrupt, 1 command done, 2 response timeout, 3 auto-stop done, 4 data timeout, 5 response CRC error, 6 read CRC error, 7 write CRC error. The bit stays set until it is cleared.
- R3: `evt_xfer[0]` (block done) sets `sts0[5]` and `evt_xfer[1]` (multi-block done) sets `sts0[4]`. Both bits are sticky.
- R4: A write with `reg_sel`=1 clears each `sts1` bit whose data bit is 1. A write with `reg_sel`=0 does the same for `sts0[7:4]` only. Data bits at 0 leave their status bits unchanged.
- R5: When an event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R6: `sts0[1]`, `sts0[2]` and `sts0[3]` follow the write-protect, second detect and first detect pins after `SYNC_STAGES` clock edges. `sts2[4]` and `sts2[5]` show `cmd_busy` and `dat_busy` directly. `sts0[0]` reads 0.
- R7: `blk_cfg[13]` selects `pin_gpi_cd` as the detect source, and it takes priority over `blk_cfg[14]`, which selects `pin_dat3_cd`. With neither bit set the card reads absent. When `blk_cfg[12]` is 1 the card is present while the pin is high; when it is 0 the card is present while the pin is low.
- R8: Any change of the qualified detect level sets `sts0[6]`. A change from absent to present also sets `sts0[7]`. Both appear `SYNC_STAGES`+1 edges after the pin moves, and a change caused by rewriting the configuration counts the same way.
- R9: `reg_sel`=3 writes `mask0`, in which only bits 7:4 are kept and bits 3:0 read 0. `reg_sel`=4 writes `mask1`, in which bit 0 reads 0.
- R10: `irq` = `blk_cfg[15]` AND (any bit of `sts0 & mask0` OR any bit of `sts1 & mask1`). It therefore follows register state in the same cycle.
- R11: `reg_sel`=5 writes all 16 bits of `blk_cfg`: bit 11 is CRC-abort enable and bits 10:0 are the block size minus one. `reg_sel`=2 writes only `sts2[7]`, the clock-freeze enable.
- R12: Writes with `reg_sel` 6 or 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 sts0, 1 sts1, 2 sts2, 3 mask0, 4 mask1, 5 blk_cfg) |
| reg_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| evt_cmd | input | 8 | Command/data event pulses in sts1 bit order |
| evt_xfer | input | 2 | Block done (0) and multi-block done (1) pulses |
| cmd_busy | input | 1 | Command line busy level |
| dat_busy | input | 1 | Data line busy level |
| pin_wp | input | 1 | Write-protect pin, asynchronous |
| pin_gpi_cd | input | 1 | First card-detect pin, asynchronous |
| pin_dat3_cd | input | 1 | Second card-detect pin, asynchronous |
| sts0 | output | 8 | Status byte 0 |
| sts1 | output | 8 | Status byte 1 |
| sts2 | output | 8 | Status byte 2 |
| mask0 | output | 8 | Interrupt mask 0 |
| mask1 | output | 8 | Interrupt mask 1 |
| blk_cfg | output | 16 | Block-length and detect configuration |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with `SYNC_STAGES` = 3 instead of the default 2. The pin-to-status latency then differs from a plain two-flop assumption, so a synchronizer chain that is one stage short or one stage long fails the cycle-exact detect checks. With this depth the bench can also sample the window in which the live pin bit has already moved but the sticky insertion flag has not yet set. The random phase mixes clears, events and masks on every cycle, which regularly produces same-cycle collisions between a set and a clear.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_W  = 16;

    typedef enum logic [2:0] {
        SEL_STS0   = 3'd0,
        SEL_STS1   = 3'd1,
        SEL_STS2   = 3'd2,
        SEL_MASK0  = 3'd3,
        SEL_MASK1  = 3'd4,
        SEL_BLKCFG = 3'd5
    } reg_sel_e;

    // configuration word fields
    localparam int CFG_GIE      = 15;
    localparam int CFG_DAT3_SEL = 14;
    localparam int CFG_GPI_SEL  = 13;
    localparam int CFG_POL_HIGH = 12;

    // status-2 fields
    localparam int S2_CMD_BUSY = 4;
    localparam int S2_DAT_BUSY = 5;
    localparam int S2_FREEZE   = 7;

    // implemented bits
    localparam logic [BYTE_W-1:0] STS0_STICKY = 8'hF0;
    localparam logic [BYTE_W-1:0] STS1_STICKY = 8'hFF;
    localparam logic [BYTE_W-1:0] MASK0_IMPL  = 8'hF0;
    localparam logic [BYTE_W-1:0] MASK1_IMPL  = 8'hFE;

    typedef struct packed {
        logic gpi_sel;
        logic dat3_sel;
        logic pol_high;
    } detect_cfg_t;

    function automatic detect_cfg_t decode_detect(input logic [CFG_W-1:0] cfg);
        detect_cfg_t d;
        d.gpi_sel  = cfg[CFG_GPI_SEL];
        d.dat3_sel = cfg[CFG_DAT3_SEL];
        d.pol_high = cfg[CFG_POL_HIGH];
        return d;
    endfunction

    // qualified card-present level; first pin wins over second
    function automatic logic card_present(input detect_cfg_t d,
                                          input logic gpi, input logic dat3);
        logic raw;
        if (d.gpi_sel)       raw = gpi;
        else if (d.dat3_sel) raw = dat3;
        else                 return 1'b0;
        return d.pol_high ? raw : ~raw;
    endfunction

endpackage

// File: rtl/sdh_pin_sync.sv
module sdh_pin_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sdh_card_detect.sv
module sdh_card_detect
    import sdh_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  detect_cfg_t cfg,
    input  logic        gpi_s,
    input  logic        dat3_s,
    output logic        insert_evt,
    output logic        change_evt
);
    logic present;
    logic present_q;

    always_comb present = card_present(cfg, gpi_s, dat3_s);

    always_ff @(posedge clk) begin
        if (rst) present_q <= 1'b0;
        else     present_q <= present;
    end

    assign change_evt = present ^ present_q;
    assign insert_evt = present & ~present_q;
endmodule

// File: rtl/sdh_sticky_reg.sv
module sdh_sticky_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);
    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= ((q & ~clr) | set) & IMPL;
    end
endmodule

// File: rtl/sdh_irq_unit.sv
module sdh_irq_unit
    import sdh_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    input  logic [7:0]  evt_cmd,
    input  logic [1:0]  evt_xfer,
    input  logic        cmd_busy,
    input  logic        dat_busy,
    input  logic        pin_wp,
    input  logic        pin_gpi_cd,
    input  logic        pin_dat3_cd,
    output logic [7:0]  sts0,
    output logic [7:0]  sts1,
    output logic [7:0]  sts2,
    output logic [7:0]  mask0,
    output logic [7:0]  mask1,
    output logic [15:0] blk_cfg,
    output logic        irq
);
    localparam int NPINS = 3;

    logic [NPINS-1:0]  pins_s;
    logic              wp_s, gpi_s, dat3_s;
    logic              ins_evt, chg_evt;
    logic [BYTE_W-1:0] s0_set, s0_clr, s0_q;
    logic [BYTE_W-1:0] s1_clr;
    logic              freeze_q;
    logic [BYTE_W-1:0] wbyte;
    reg_sel_e          sel;

    assign sel   = reg_sel_e'(reg_sel);
    assign wbyte = reg_wdata[BYTE_W-1:0];

    sdh_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(NPINS)) i_sync (
        .clk (clk),
        .rst (rst),
        .din ({pin_dat3_cd, pin_gpi_cd, pin_wp}),
        .dout(pins_s)
    );
    assign {dat3_s, gpi_s, wp_s} = pins_s;

    sdh_card_detect i_detect (
        .clk       (clk),
        .rst       (rst),
        .cfg       (decode_detect(blk_cfg)),
        .gpi_s     (gpi_s),
        .dat3_s    (dat3_s),
        .insert_evt(ins_evt),
        .change_evt(chg_evt)
    );

    always_comb begin
        s0_set = {ins_evt, chg_evt, evt_xfer[0], evt_xfer[1], 4'b0000};
        s0_clr = (reg_wr && sel == SEL_STS0) ? wbyte : '0;
        s1_clr = (reg_wr && sel == SEL_STS1) ? wbyte : '0;
    end

    sdh_sticky_reg #(.WIDTH(BYTE_W), .IMPL(STS0_STICKY)) i_sts0 (
        .clk(clk), .rst(rst), .set(s0_set), .clr(s0_clr), .q(s0_q)
    );

    sdh_sticky_reg #(.WIDTH(BYTE_W), .IMPL(STS1_STICKY)) i_sts1 (
        .clk(clk), .rst(rst), .set(evt_cmd), .clr(s1_clr), .q(sts1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask0    <= '0;
            mask1    <= '0;
            blk_cfg  <= '0;
            freeze_q <= 1'b0;
        end else if (reg_wr) begin
            case (sel)
                SEL_MASK0:  mask0    <= wbyte & MASK0_IMPL;
                SEL_MASK1:  mask1    <= wbyte & MASK1_IMPL;
                SEL_BLKCFG: blk_cfg  <= reg_wdata;
                SEL_STS2:   freeze_q <= wbyte[S2_FREEZE];
                default: ;
            endcase
        end
    end

    always_comb begin
        sts0 = {s0_q[7:4], gpi_s, dat3_s, wp_s, 1'b0};
        sts2 = '0;
        sts2[S2_CMD_BUSY] = cmd_busy;
        sts2[S2_DAT_BUSY] = dat_busy;
        sts2[S2_FREEZE]   = freeze_q;
        irq = blk_cfg[CFG_GIE] & ((|(s0_q & mask0)) | (|(sts1 & mask1)));
    end
endmodule

// File: rtl/sdh_irq_unit_chk.sv
module sdh_irq_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [2:0]  reg_sel,
    input logic [15:0] reg_wdata,
    input logic [7:0]  evt_cmd,
    input logic [1:0]  evt_xfer,
    input logic [7:0]  sts0,
    input logic [7:0]  sts1,
    input logic [7:0]  mask0,
    input logic [7:0]  mask1,
    input logic [15:0] blk_cfg,
    input logic        irq
);
    p_sts1_set_r2: assert property (@(posedge clk) disable iff (rst)
        (evt_cmd != 8'd0) |=> ((sts1 & $past(evt_cmd)) == $past(evt_cmd)));

    p_sts1_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!(reg_wr && reg_sel == 3'd1) && evt_cmd == 8'd0) |=> $stable(sts1));

    p_sts1_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 3'd1 && evt_cmd == 8'd0)
        |=> ((sts1 & $past(reg_wdata[7:0])) == 8'd0));

    p_sts0_xfer_r3: assert property (@(posedge clk) disable iff (rst)
        evt_xfer[0] |=> sts0[5]);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !blk_cfg[15] |-> !irq);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
        (blk_cfg[15] && (sts1 & mask1) != 8'd0) |-> irq);

    p_mask_rsvd_r9: assert property (@(posedge clk) disable iff (rst)
        (mask0[3:0] == 4'd0) && !mask1[0] && !sts0[0]);
endmodule

bind sdh_irq_unit sdh_irq_unit_chk i_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .evt_cmd(evt_cmd), .evt_xfer(evt_xfer),
    .sts0(sts0), .sts1(sts1), .mask0(mask0), .mask1(mask1),
    .blk_cfg(blk_cfg), .irq(irq)
);

// File: tb/test_sdh_irq_unit.sv
`timescale 1ns/1ps
module test_sdh_irq_unit;
    localparam int SYNC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  evt_cmd = '0;
    logic [1:0]  evt_xfer = '0;
    logic        cmd_busy = 1'b0, dat_busy = 1'b0;
    logic        pin_wp = 1'b0, pin_gpi_cd = 1'b0, pin_dat3_cd = 1'b0;
    logic [7:0]  sts0, sts1, sts2, mask0, mask1;
    logic [15:0] blk_cfg;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdh_irq_unit #(.SYNC_STAGES(SYNC)) i_sdh_irq_unit (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .evt_cmd(evt_cmd), .evt_xfer(evt_xfer),
        .cmd_busy(cmd_busy), .dat_busy(dat_busy), .pin_wp(pin_wp),
        .pin_gpi_cd(pin_gpi_cd), .pin_dat3_cd(pin_dat3_cd),
        .sts0(sts0), .sts1(sts1), .sts2(sts2), .mask0(mask0),
        .mask1(mask1), .blk_cfg(blk_cfg), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] c, input logic [1:0] x);
        evt_cmd = c; evt_xfer = x;
        @(negedge clk);
        evt_cmd = '0; evt_xfer = '0;
    endtask

    function automatic logic [7:0] f_sticky(input logic [7:0] q, input logic [7:0] clr,
                                            input logic [7:0] set);
        return (q & ~clr) | set;
    endfunction

    function automatic logic f_irq(input logic [15:0] cfg, input logic [7:0] s0,
                                   input logic [7:0] m0, input logic [7:0] s1,
                                   input logic [7:0] m1);
        return cfg[15] & ((|(s0 & m0)) | (|(s1 & m1)));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  m_s0, m_s1, m_m0, m_m1, m_s2;
        logic [15:0] m_cfg;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 sts0", sts0, 0); chk("R1 sts1", sts1, 0); chk("R1 sts2", sts2, 0);
        chk("R1 mask0", mask0, 0); chk("R1 mask1", mask1, 0);
        chk("R1 blk_cfg", blk_cfg, 0); chk("R1 irq", irq, 0);

        // R2 sticky command events
        pulse(8'h24, 2'b00);
        chk("R2 set", sts1, 8'h24);
        @(negedge clk);
        chk("R2 hold", sts1, 8'h24);
        chk("R10 unmasked", irq, 0);

        // R9 mask1 reserved bit
        wr(3'd4, 16'h00FF);
        chk("R9 mask1", mask1, 8'hFE);
        chk("R10 gie off", irq, 0);

        // R11 config word
        wr(3'd5, 16'h89FF);
        chk("R11 blk_cfg", blk_cfg, 16'h89FF);
        chk("R10 gie on", irq, 1);

        // R5 event beats clear
        reg_wr = 1'b1; reg_sel = 3'd1; reg_wdata = 16'h0004; evt_cmd = 8'h04;
        @(negedge clk);
        reg_wr = 1'b0; evt_cmd = '0;
        chk("R5 event wins", sts1, 8'h24);

        // R4 write-one-to-clear
        wr(3'd1, 16'h0020); chk("R4 clear bit5", sts1, 8'h04);
        wr(3'd1, 16'h0000); chk("R4 zero write", sts1, 8'h04);
        wr(3'd1, 16'h0004); chk("R4 clear all", sts1, 8'h00);
        chk("R10 irq drops", irq, 0);

        // R3 transfer events, R9 mask0
        pulse(8'h00, 2'b11);
        chk("R3 xfer", sts0, 8'h30);
        wr(3'd3, 16'h00FF);
        chk("R9 mask0", mask0, 8'hF0);
        chk("R10 sts0 src", irq, 1);
        wr(3'd0, 16'h000F); chk("R4 sts0 low bits", sts0, 8'h30);
        wr(3'd0, 16'h0020); chk("R4 sts0 bit5", sts0, 8'h10);
        pulse(8'h00, 2'b01); chk("R3 block done", sts0, 8'h30);
        wr(3'd0, 16'h00FF); chk("R4 sts0 all", sts0, 8'h00);

        // R12 ignored selects
        pulse(8'h81, 2'b00);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        chk("R12 sts1", sts1, 8'h81); chk("R12 sts0", sts0, 8'h00);
        chk("R12 mask0", mask0, 8'hF0); chk("R12 mask1", mask1, 8'hFE);
        chk("R12 cfg", blk_cfg, 16'h89FF); chk("R12 sts2", sts2, 8'h00);
        wr(3'd1, 16'h00FF);

        // R11 freeze bit, R6 busy levels
        wr(3'd2, 16'h00FF); chk("R11 freeze", sts2, 8'h80);
        cmd_busy = 1'b1; @(negedge clk); chk("R6 cmd busy", sts2, 8'h90);
        dat_busy = 1'b1; @(negedge clk); chk("R6 dat busy", sts2, 8'hB0);
        wr(3'd2, 16'h0000); chk("R11 freeze off", sts2, 8'h30);
        cmd_busy = 1'b0; dat_busy = 1'b0; @(negedge clk);

        // R6 write-protect latency
        pin_wp = 1'b1;
        repeat (SYNC-1) @(negedge clk);
        chk("R6 wp early", sts0, 8'h00);
        @(negedge clk);
        chk("R6 wp", sts0, 8'h02);
        pin_wp = 1'b0;
        repeat (SYNC+1) @(negedge clk);

        // R7/R8 detect via first pin, active low
        pin_gpi_cd = 1'b1;
        repeat (SYNC+1) @(negedge clk);
        chk("R6 gpi level", sts0, 8'h08);
        wr(3'd5, 16'hA000);
        repeat (2) @(negedge clk);
        chk("R7 absent", sts0, 8'h08);
        pin_gpi_cd = 1'b0;
        repeat (SYNC) @(negedge clk);
        chk("R8 not yet", sts0, 8'h00);
        @(negedge clk);
        chk("R8 inserted", sts0, 8'hC0);
        chk("R10 insert irq", irq, 1);
        wr(3'd0, 16'h00C0);
        pin_gpi_cd = 1'b1;
        repeat (SYNC+2) @(negedge clk);
        chk("R8 removed", sts0, 8'h48);
        wr(3'd0, 16'h00FF);

        // R7 priority of first pin, active high
        wr(3'd5, 16'hF000);
        repeat (2) @(negedge clk);
        chk("R7 priority", sts0, 8'hC8);
        wr(3'd0, 16'h00FF);
        wr(3'd5, 16'hD000);
        repeat (2) @(negedge clk);
        chk("R8 cfg change", sts0, 8'h48);
        wr(3'd0, 16'h00FF);
        pin_dat3_cd = 1'b1;
        repeat (SYNC+2) @(negedge clk);
        chk("R7 second pin", sts0, 8'hCC);

        // cleanup to a known state
        wr(3'd5, 16'h0000);
        pin_gpi_cd = 1'b0; pin_dat3_cd = 1'b0;
        repeat (SYNC+2) @(negedge clk);
        wr(3'd0, 16'h00FF); wr(3'd1, 16'h00FF);
        wr(3'd3, 16'h0000); wr(3'd4, 16'h0000);
        chk("R4 cleanup", {sts0, sts1}, 16'h0000);

        // random phase, R2 R3 R4 R5 R9 R10 R11 R12
        m_s0 = 0; m_s1 = 0; m_m0 = 0; m_m1 = 0; m_cfg = 0; m_s2 = 0;
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  sel;
            logic [15:0] d;
            logic        w;
            logic [7:0]  ec;
            logic [1:0]  ex;
            w   = ($urandom % 3) == 0;
            sel = 3'($urandom % 8);
            d   = 16'($urandom) & 16'h8FFF;
            ec  = (($urandom % 2) == 0) ? 8'($urandom) : 8'h00;
            ex  = 2'($urandom);
            reg_wr = w; reg_sel = sel; reg_wdata = d;
            evt_cmd = ec; evt_xfer = ex;
            cmd_busy = 1'($urandom); dat_busy = 1'($urandom);
            m_s1 = f_sticky(m_s1, (w && sel == 3'd1) ? d[7:0] : 8'h00, ec);
            m_s0 = f_sticky(m_s0, (w && sel == 3'd0) ? (d[7:0] & 8'hF0) : 8'h00,
                            {2'b00, ex[0], ex[1], 4'h0});
            if (w && sel == 3'd3) m_m0 = d[7:0] & 8'hF0;
            if (w && sel == 3'd4) m_m1 = d[7:0] & 8'hFE;
            if (w && sel == 3'd5) m_cfg = d;
            if (w && sel == 3'd2) m_s2 = {d[7], 7'd0};
            @(negedge clk);
            chk("R2 R5 sts1", sts1, m_s1);
            chk("R3 R4 sts0", sts0, m_s0);
            chk("R9 masks", {mask0, mask1}, {m_m0, m_m1});
            chk("R11 R12 cfg", blk_cfg, m_cfg);
            chk("R6 R11 sts2", sts2, m_s2 | {2'b00, dat_busy, cmd_busy, 4'h0});
            chk("R10 irq", irq, f_irq(m_cfg, m_s0, m_m0, m_s1, m_m1));
        end
        reg_wr = 1'b0; evt_cmd = '0; evt_xfer = '0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule